// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of 32 transfer channels the transfer engine serves next. Each channel has a hardware request line from its peripheral. Per-channel controls set how each request is treated:

- an enable bit,
- a mask for the hardware request,
- a one-cycle software trigger,
- a priority-class bit.

The arbiter forms the set of eligible channels. It picks a winner, first by class and then by lowest index. It presents the winner as a registered channel index with a valid flag.

A grant, once issued, is held unchanged until the engine reports the end of service with a done pulse. In the cycle after the done pulse, the grant drops and a one-cycle acknowledge is raised on the served channel. The processor core always has first claim on the bus: while its bus request is asserted, no new grant is started. A software trigger is remembered until its channel is granted, so software can start a transfer on any enabled channel even when no peripheral is asking.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant_valid` is 0 and `chan_ack` is all zeros.
- R2: Take an idle arbiter with a single eligible channel k (enabled, hardware request high, mask bit 0), with `core_bus_req` low. At the next clock edge, `grant_valid` becomes 1 and `grant_idx` equals k.
- R3: Among eligible channels of the same class, the channel with the lowest index is granted.
- R4: An eligible channel whose `chan_prio` bit is 1 (high class) is granted ahead of every eligible channel whose `chan_prio` bit is 0 (low class), regardless of index.
- R5: A hardware request on a channel whose `hw_mask` bit is 1 never makes that channel eligible.
- R6: A one-cycle `sw_trig` pulse on an enabled channel is held until that channel is granted. It then clears, so the pulse causes exactly one grant. The pulse works whether or not the channel is masked or has a hardware request.
- R7: A channel whose `chan_en` bit is 0 is never granted. A `sw_trig` pulse on such a channel is discarded, so enabling the channel later does not produce a grant from that pulse.
- R8: A clock edge at which `core_bus_req` is 1 never starts a new grant. Once `core_bus_req` returns to 0, a pending request is granted at the next edge.
- R9: While `grant_valid` is 1 and `xfer_done` is 0, `grant_valid` and `grant_idx` stay unchanged, whatever the requests do.
- R10: After an edge at which `grant_valid` and `xfer_done` are both 1, `grant_valid` is 0 and `chan_ack` has exactly bit `grant_idx` set for one cycle. At all other times `chan_ack` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hw_req | input | 32 | Peripheral request per channel |
| hw_mask | input | 32 | 1 masks the channel's hardware request |
| chan_en | input | 32 | 1 enables the channel |
| chan_prio | input | 32 | 1 places the channel in the high class |
| sw_trig | input | 32 | One-cycle software request pulse per channel |
| core_bus_req | input | 1 | Processor core claims the bus; blocks new grants |
| xfer_done | input | 1 | Engine pulse: service of the granted channel has ended |
| grant_valid | output | 1 | A channel is granted |
| grant_idx | output | 5 | Index of the granted channel |
| chan_ack | output | 32 | One-cycle acknowledge on the served channel |

## Verification
Some properties hold on every cycle, and the assertions check these:
- a grant never starts while the core holds the bus;
- a held grant keeps its index until done;
- the acknowledge is at most one-hot and names the channel that was just released;
- every granted channel was enabled when it was chosen.

Other behaviour depends on what was requested, so only the bench scenarios can show it:
- the choice of winner, by class and then by index;
- the effect of masking;
- the retention and single use of software triggers;
- the loss of a trigger on a disabled channel.

The bench sweeps every channel alone and many mixed request and priority patterns. It compares each winner against an arithmetic model.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_t;

  // class 0 = low, class 1 = high
  localparam int unsigned NUM_CLASSES = 2;

endpackage

// File: rtl/dma_sw_latch.sv
// Holds software triggers until the channel is granted.
module dma_sw_latch #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] sw_trig,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] pend
);

  logic [NUM_CH-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      // a trigger arriving in the grant cycle survives the clear
      pend_q <= ((pend_q & ~clr_vec) | sw_trig) & chan_en;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/dma_lowest_pick.sv
// Finds the lowest set bit of a request vector.
module dma_lowest_pick #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);

  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
      end
    end
  end

  assign found = |req;

endmodule

// File: rtl/dma_class_select.sv
// Two-class selection: the high class first, then the lowest index.
module dma_class_select #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] elig,
  input  logic [NUM_CH-1:0] prio_hi,
  output logic              any,
  output logic [IDX_W-1:0]  win_idx
);

  import dma_arb_pkg::*;

  logic [NUM_CLASSES-1:0] cls_found;
  logic [IDX_W-1:0]       cls_idx [NUM_CLASSES];

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    logic [NUM_CH-1:0] cls_req;
    assign cls_req = (c == 0) ? (elig & ~prio_hi) : (elig & prio_hi);

    dma_lowest_pick #(
      .NUM_CH(NUM_CH),
      .IDX_W (IDX_W)
    ) u_pick (
      .req  (cls_req),
      .found(cls_found[c]),
      .idx  (cls_idx[c])
    );
  end

  assign any     = |cls_found;
  assign win_idx = cls_found[1] ? cls_idx[1] : cls_idx[0];

endmodule

// File: rtl/dma_grant_ctrl.sv
// Registered grant, held until done, followed by a one-cycle acknowledge.
module dma_grant_ctrl #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              core_bus_req,
  input  logic              xfer_done,
  output logic              issue,
  output logic              grant_valid,
  output logic [IDX_W-1:0]  grant_idx,
  output logic [NUM_CH-1:0] chan_ack
);

  import dma_arb_pkg::*;

  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  arb_state_t        state_q;
  logic              gv_q;
  logic [IDX_W-1:0]  gi_q;
  logic [NUM_CH-1:0] ack_q;

  assign issue = (state_q == ARB_IDLE) && any && !core_bus_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      gv_q    <= 1'b0;
      gi_q    <= '0;
      ack_q   <= '0;
    end else begin
      ack_q <= '0;
      case (state_q)
        ARB_IDLE: begin
          if (issue) begin
            state_q <= ARB_BUSY;
            gv_q    <= 1'b1;
            gi_q    <= win_idx;
          end
        end
        ARB_BUSY: begin
          if (xfer_done) begin
            state_q <= ARB_IDLE;
            gv_q    <= 1'b0;
            ack_q   <= ONE << gi_q;
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign grant_valid = gv_q;
  assign grant_idx   = gi_q;
  assign chan_ack    = ack_q;

endmodule

// File: rtl/dma_req_arbiter.sv
// Top: channel request arbiter for the transfer engine.
module dma_req_arbiter #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] hw_mask,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] chan_prio,
  input  logic [NUM_CH-1:0] sw_trig,
  input  logic              core_bus_req,
  input  logic              xfer_done,
  output logic              grant_valid,
  output logic [IDX_W-1:0]  grant_idx,
  output logic [NUM_CH-1:0] chan_ack
);

  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  logic [NUM_CH-1:0] sw_pend;
  logic [NUM_CH-1:0] elig;
  logic [NUM_CH-1:0] clr_vec;
  logic              any;
  logic [IDX_W-1:0]  win_idx;
  logic              issue;

  assign elig    = chan_en & ((hw_req & ~hw_mask) | sw_pend);
  assign clr_vec = issue ? (ONE << win_idx) : '0;

  dma_sw_latch #(
    .NUM_CH(NUM_CH)
  ) u_sw (
    .clk    (clk),
    .rst    (rst),
    .sw_trig(sw_trig),
    .chan_en(chan_en),
    .clr_vec(clr_vec),
    .pend   (sw_pend)
  );

  dma_class_select #(
    .NUM_CH(NUM_CH),
    .IDX_W (IDX_W)
  ) u_sel (
    .elig   (elig),
    .prio_hi(chan_prio),
    .any    (any),
    .win_idx(win_idx)
  );

  dma_grant_ctrl #(
    .NUM_CH(NUM_CH),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .any         (any),
    .win_idx     (win_idx),
    .core_bus_req(core_bus_req),
    .xfer_done   (xfer_done),
    .issue       (issue),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .chan_ack    (chan_ack)
  );

endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] chan_en,
  input logic              core_bus_req,
  input logic              xfer_done,
  input logic              grant_valid,
  input logic [IDX_W-1:0]  grant_idx,
  input logic [NUM_CH-1:0] chan_ack
);

  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  logic [NUM_CH-1:0] en_q;
  always_ff @(posedge clk) en_q <= chan_en;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!grant_valid && chan_ack == '0));

  p_core_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (core_bus_req && !grant_valid) |=> !grant_valid);

  p_grant_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !xfer_done) |=> (grant_valid && $stable(grant_idx)));

  p_ack_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_ack));

  p_ack_served_r10: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && xfer_done) |=>
      (!grant_valid && chan_ack == (ONE << $past(grant_idx))));

  p_granted_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_valid) |-> en_q[grant_idx]);

endmodule

bind dma_req_arbiter dma_arb_checker #(
  .NUM_CH(NUM_CH),
  .IDX_W (IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chan_en     (chan_en),
  .core_bus_req(core_bus_req),
  .xfer_done   (xfer_done),
  .grant_valid (grant_valid),
  .grant_idx   (grant_idx),
  .chan_ack    (chan_ack)
);

// File: tb/test_dma_req_arbiter.sv
`timescale 1ns/1ps
module test_dma_req_arbiter;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  hw_req, hw_mask, chan_en, chan_prio, sw_trig;
  logic          core_bus_req, xfer_done;
  logic          grant_valid;
  logic [4:0]    grant_idx;
  logic [N-1:0]  chan_ack;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_req_arbiter #(.NUM_CH(N)) i_dma_req_arbiter (
    .clk(clk), .rst(rst), .hw_req(hw_req), .hw_mask(hw_mask),
    .chan_en(chan_en), .chan_prio(chan_prio), .sw_trig(sw_trig),
    .core_bus_req(core_bus_req), .xfer_done(xfer_done),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .chan_ack(chan_ack)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model: high class first, then lowest index; -1 if nothing eligible.
  function automatic int model_win(input logic [N-1:0] elig, input logic [N-1:0] hi);
    logic [N-1:0] pool;
    pool = ((elig & hi) != '0) ? (elig & hi) : elig;
    for (int i = 0; i < N; i++) if (pool[i]) return i;
    return -1;
  endfunction

  // End service on the current grant, expecting channel k to be acknowledged.
  task automatic finish(input int k);
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    chk("R10 valid drop", 64'(grant_valid), 64'(0));
    chk("R10 ack bit", 64'(chan_ack), 64'(32'h1 << k));
    tick();
    chk("R10 ack clears", 64'(chan_ack), 64'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hw_req = '0; hw_mask = '0; chan_en = '1; chan_prio = '0;
    sw_trig = '0; core_bus_req = 1'b0; xfer_done = 1'b0;
    tick(); tick();
    chk("R1 reset valid", 64'(grant_valid), 64'(0));
    chk("R1 reset ack", 64'(chan_ack), 64'(0));
    rst = 1'b0;
    tick();
    chk("R1 idle after reset", 64'(grant_valid), 64'(0));

    // R2: each channel alone
    for (int k = 0; k < N; k++) begin
      hw_req = 32'h1 << k;
      tick();
      hw_req = '0;
      chk("R2 valid", 64'(grant_valid), 64'(1));
      chk("R2 index", 64'(grant_idx), 64'(k));
      finish(k);
    end

    // R3/R4: mixed requests and classes
    for (int n = 0; n < 64; n++) begin
      logic [N-1:0] rq;
      logic [N-1:0] pr;
      int e;
      rq = (32'h1 << (n % 32)) | (32'h1 << ((n * 11 + 7) % 32));
      if (n % 3 == 0) rq = rq | (32'h1 << ((n * 5 + 3) % 32));
      pr = 32'(n + 1) * 32'h9E3779B9;
      if (n < 16) pr = '0;
      e = model_win(rq, pr);
      hw_req = rq; chan_prio = pr;
      tick();
      hw_req = '0;
      chk(n < 16 ? "R3 lowest index" : "R4 class order", 64'(grant_idx), 64'(e));
      finish(e);
    end
    chan_prio = '0;

    // R4: high channel 31 beats low channel 0
    hw_req = 32'h8000_0001; chan_prio = 32'h8000_0000;
    tick(); hw_req = '0;
    chk("R4 high beats low", 64'(grant_idx), 64'(31));
    finish(31);
    chan_prio = '0;

    // R5: masking
    hw_req = '1; hw_mask = ~(32'h1 << 17);
    tick(); hw_req = '0;
    chk("R5 only unmasked", 64'(grant_idx), 64'(17));
    finish(17);
    hw_req = '1; hw_mask = '1;
    tick(); tick(); tick();
    chk("R5 all masked no grant", 64'(grant_valid), 64'(0));
    hw_req = '0;

    // R6: software trigger on masked channel, no hardware request
    sw_trig = 32'h1 << 9;
    tick(); sw_trig = '0;
    tick();
    chk("R6 sw grant valid", 64'(grant_valid), 64'(1));
    chk("R6 sw grant idx", 64'(grant_idx), 64'(9));
    finish(9);
    tick(); tick();
    chk("R6 sw cleared", 64'(grant_valid), 64'(0));
    sw_trig = (32'h1 << 20) | (32'h1 << 3);
    tick(); sw_trig = '0;
    tick();
    chk("R6 first of two", 64'(grant_idx), 64'(3));
    finish(3);
    chk("R6 second held", 64'(grant_valid), 64'(1));
    chk("R6 second idx", 64'(grant_idx), 64'(20));
    finish(20);
    hw_mask = '0;

    // R7: disabled channel ignores both request kinds
    chan_en = ~(32'h1 << 4);
    hw_req = 32'h1 << 4; sw_trig = 32'h1 << 4;
    tick(); sw_trig = '0;
    tick(); tick();
    chk("R7 disabled no grant", 64'(grant_valid), 64'(0));
    hw_req = '0; chan_en = '1;
    tick(); tick();
    chk("R7 trigger discarded", 64'(grant_valid), 64'(0));

    // R8: core holds the bus
    core_bus_req = 1'b1; hw_req = 32'h1 << 6;
    for (int c = 0; c < 5; c++) begin
      tick();
      chk("R8 held off", 64'(grant_valid), 64'(0));
    end
    core_bus_req = 1'b0;
    tick();
    chk("R8 grant after release", 64'(grant_idx), 64'(6));
    chk("R8 valid after release", 64'(grant_valid), 64'(1));

    // R9: grant stays put while other requests change
    for (int c = 0; c < 6; c++) begin
      hw_req = 32'h1 << c; chan_prio = 32'h1 << c;
      tick();
      chk("R9 valid held", 64'(grant_valid), 64'(1));
      chk("R9 index held", 64'(grant_idx), 64'(6));
    end
    hw_req = '0; chan_prio = '0;
    finish(6);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule